// File: doc/BRIEF.md
# EEPROM Access Controller for a Small CPU

This block connects the I/O register interface of a small processor to a byte-wide non-volatile data array of 64 locations. The array is modelled here as a register array. Software sees three registers: a 6-bit location register, an 8-bit byte register and a 2-bit command register that carries a program strobe and a fetch strobe. Each register is loaded through its own write-enable pin, and its current value is always visible on a read-back port.

A fetch copies the addressed byte into the byte register within a single access. The hardware then drops the fetch strobe by itself. A program operation stores the byte register at the addressed location, but it takes a long, parameterized number of clock cycles. During that time the program strobe reads back as 1, so software can poll it. When the time has elapsed the hardware clears the strobe and updates the array. Each accepted strobe also raises a CPU halt output for a fixed number of cycles: two for a program operation and four for a fetch.

The location and byte are captured inside the block when a program operation starts. Software may therefore change the two registers while the operation is still running without affecting it. Command writes that arrive while a program operation is busy are dropped.

Top module: `eeprom_access_ctrl`

## Requirements
- R1: The location register is 6 bits wide and the byte register is 8 bits wide. Each loads on the clock edge where its write enable is high. The command read-back uses bit 1 for the program strobe and bit 0 for the fetch strobe.
- R2: A command write with bit 1 set while idle starts a program operation. The operation stores the byte register value at the location held in the location register.
- R3: After the accepting edge, command bit 1 reads 1 for exactly WRITE_CYCLES clock cycles and then reads 0. The array holds the new byte from the cycle in which the bit reads 0.
- R4: After a program operation is accepted, halt is high for exactly 2 cycles.
- R5: A command write with bit 0 set (and bit 1 clear) while idle loads the byte register with the addressed array byte. The byte is visible on the cycle after the accepting edge. Command bit 0 reads 1 on that cycle only and reads 0 afterwards.
- R6: After a fetch is accepted, halt is high for exactly 4 cycles.
- R7: Writing the location or byte register during a busy program operation changes neither the location nor the value that the operation stores.
- R8: Any command write during a busy program operation is ignored. It starts no fetch, raises no halt and does not extend the busy period.
- R9: A command write with both bits set while idle starts only a program operation: the read-back is 2'b10 and the halt lasts 2 cycles.
- R10: A synchronous active-high reset clears all three registers, both strobes and halt, and it abandons a running program operation so the array is not written. The array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_we | input | 1 | Load the location register |
| loc_wdata | input | 6 | New location value |
| byte_we | input | 1 | Load the byte register |
| byte_wdata | input | 8 | New byte value |
| cmd_we | input | 1 | Write the command register |
| cmd_wdata | input | 2 | Bit 1 program strobe, bit 0 fetch strobe |
| loc_q | output | 6 | Location register read-back |
| byte_q | output | 8 | Byte register read-back |
| cmd_q | output | 2 | Command read-back: bit 1 busy program, bit 0 fetch strobe |
| halt | output | 1 | CPU stall request |

## Verification
Random program operations, each followed by a fetch of the same location, cover addresses and bytes drawn from a fixed seed. Repeated fetches of locations written earlier show whether a later write disturbed an earlier one. The edge locations 0 and 63 are tried directly. Register writes and command writes issued during a busy period separate a design that captures the location and byte at the start from one that reads them live, and a design that drops commands while busy from one that accepts them. A both-bits command and a reset in the middle of a program operation separate the strobe priority and show that an abandoned operation leaves the old byte in place.

// File: rtl/eeprom_access_ctrl.sv
module eeprom_access_ctrl #(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 50,
  parameter int WR_HALT      = 2,
  parameter int RD_HALT      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loc_we,
  input  logic [ADDR_W-1:0] loc_wdata,
  input  logic              byte_we,
  input  logic [DATA_W-1:0] byte_wdata,
  input  logic              cmd_we,
  input  logic [1:0]        cmd_wdata,
  output logic [ADDR_W-1:0] loc_q,
  output logic [DATA_W-1:0] byte_q,
  output logic [1:0]        cmd_q,
  output logic              halt
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(WRITE_CYCLES + 1);
  localparam int HMAX  = (WR_HALT > RD_HALT) ? WR_HALT : RD_HALT;
  localparam int HW    = $clog2(HMAX + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] loc_r, lat_loc;
  logic [DATA_W-1:0] byte_r, lat_byte;
  logic              busy, fetch_flag;
  logic [CW-1:0]     wr_cnt;
  logic [HW-1:0]     halt_cnt;

  wire wr_go   = cmd_we && cmd_wdata[1] && !busy;
  wire rd_go   = cmd_we && cmd_wdata[0] && !cmd_wdata[1] && !busy;
  wire wr_done = busy && (wr_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_r      <= '0;
      byte_r     <= '0;
      lat_loc    <= '0;
      lat_byte   <= '0;
      busy       <= 1'b0;
      fetch_flag <= 1'b0;
      wr_cnt     <= '0;
      halt_cnt   <= '0;
    end else begin
      if (loc_we) loc_r <= loc_wdata;
      if (rd_go) byte_r <= mem[loc_r];
      else if (byte_we) byte_r <= byte_wdata;
      fetch_flag <= rd_go;
      if (wr_go) begin
        busy     <= 1'b1;
        wr_cnt   <= CW'(WRITE_CYCLES - 1);
        lat_loc  <= loc_r;
        lat_byte <= byte_r;
      end else if (wr_done) begin
        busy <= 1'b0;
      end else if (busy) begin
        wr_cnt <= wr_cnt - 1'b1;
      end
      if (wr_go) halt_cnt <= HW'(WR_HALT);
      else if (rd_go) halt_cnt <= HW'(RD_HALT);
      else if (halt_cnt != '0) halt_cnt <= halt_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && wr_done) mem[lat_loc] <= lat_byte;
  end

  assign loc_q  = loc_r;
  assign byte_q = byte_r;
  assign cmd_q  = {busy, fetch_flag};
  assign halt   = (halt_cnt != '0);

  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_cnt != '0) |=> cmd_q[1]);
  assert_busy_clear_R3: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> !cmd_q[1]);
  assert_wr_halt_R4: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> (halt && halt_cnt == HW'(WR_HALT)));
  assert_fetch_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (fetch_flag && !rd_go) |=> !cmd_q[0]);
  assert_rd_halt_R6: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> (halt && halt_cnt == HW'(RD_HALT)));
  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr_done) |=> ($stable(lat_loc) && $stable(lat_byte)));
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_we) |=> !cmd_q[0]);
  assert_both_bits_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_wdata == 2'b11 && !busy) |=> (cmd_q == 2'b10));
  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (cmd_q == 2'b00 && !halt));
endmodule

// File: tb/sim_eeprom_access_ctrl.sv
module sim_eeprom_access_ctrl;
  localparam int W = 50;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       loc_we = 1'b0, byte_we = 1'b0, cmd_we = 1'b0;
  logic [5:0] loc_wdata = '0;
  logic [7:0] byte_wdata = '0;
  logic [1:0] cmd_wdata = '0;
  logic [5:0] loc_q;
  logic [7:0] byte_q;
  logic [1:0] cmd_q;
  logic       halt;

  int errors = 0, checks = 0, cyc = 0;
  logic [7:0] model [64];
  bit         known [64];
  bit         done = 1'b0;

  eeprom_access_ctrl #(.WRITE_CYCLES(W)) u0 (
    .clk, .rst, .loc_we, .loc_wdata, .byte_we, .byte_wdata,
    .cmd_we, .cmd_wdata, .loc_q, .byte_q, .cmd_q, .halt);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [1:0] exp_cmd_after(input bit [1:0] c);
    return c[1] ? 2'b10 : {1'b0, c[0]};
  endfunction

  task automatic set_loc(input logic [5:0] a);
    @(negedge clk); loc_we = 1'b1; loc_wdata = a;
    @(negedge clk); loc_we = 1'b0;
  endtask

  task automatic set_byte(input logic [7:0] d);
    @(negedge clk); byte_we = 1'b1; byte_wdata = d;
    @(negedge clk); byte_we = 1'b0;
  endtask

  task automatic cmd(input logic [1:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = c;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic do_write(input logic [5:0] a, input logic [7:0] d);
    int c0;
    set_loc(a);
    set_byte(d);
    cmd(2'b10);
    c0 = cyc;
    chk(cmd_q[1] == 1'b1, "R2", cmd_q, 2);
    while (halt && cyc - c0 < 20) @(negedge clk);
    chk(cyc - c0 == 2, "R4", cyc - c0, 2);
    while (cmd_q[1] && cyc - c0 < W + 20) @(negedge clk);
    chk(cyc - c0 == W, "R3", cyc - c0, W);
    model[a] = d;
    known[a] = 1'b1;
  endtask

  task automatic do_read(input logic [5:0] a, input string req);
    int c0;
    set_loc(a);
    cmd(2'b01);
    c0 = cyc;
    chk(byte_q == model[a], req, byte_q, model[a]);
    chk(cmd_q == 2'b01, "R5", cmd_q, 1);
    while (halt && cyc - c0 < 20) @(negedge clk);
    chk(cyc - c0 == 4, "R6", cyc - c0, 4);
    chk(cmd_q[0] == 1'b0, "R5", cmd_q, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c0;
    logic [7:0] hold;
    logic [5:0] a;
    logic [7:0] d;
    a = 6'($urandom(32'd11));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(cmd_q == 2'b00 && !halt, "R10", {halt, cmd_q}, 0);
    chk(loc_q == 6'd0 && byte_q == 8'd0, "R1", {loc_q, byte_q}, 0);

    set_loc(6'h2a);
    chk(loc_q == 6'h2a, "R1", loc_q, 6'h2a);
    set_byte(8'hc3);
    chk(byte_q == 8'hc3, "R1", byte_q, 8'hc3);

    do_write(6'd0, 8'h5a);
    do_write(6'd63, 8'ha5);
    do_read(6'd0, "R2");
    do_read(6'd63, "R2");

    for (int i = 0; i < 20; i++) begin
      a = 6'($urandom);
      d = 8'($urandom);
      do_write(a, d);
      do_read(a, "R2");
    end
    for (int i = 0; i < 64; i++)
      if (known[i]) do_read(6'(i), "R5");

    // R7: register writes while busy
    set_loc(6'd5);
    set_byte(8'h77);
    cmd(2'b10);
    c0 = cyc;
    set_loc(6'd9);
    set_byte(8'h11);
    while (cmd_q[1] && cyc - c0 < W + 20) @(negedge clk);
    chk(cyc - c0 == W, "R3", cyc - c0, W);
    model[5] = 8'h77;
    hold = known[9] ? model[9] : 8'h00;
    do_read(6'd5, "R7");
    if (!known[9]) begin
      do_write(6'd9, 8'h3c);
      hold = 8'h3c;
    end
    do_read(6'd9, "R7");
    chk(model[9] == hold, "R7", model[9], hold);

    // R8: commands while busy
    set_loc(6'd12);
    set_byte(8'h90);
    cmd(2'b10);
    c0 = cyc;
    repeat (4) @(negedge clk);
    hold = byte_q;
    cmd(2'b01);
    chk(cmd_q[0] == 1'b0 && !halt, "R8", {halt, cmd_q}, 2);
    chk(byte_q == hold, "R8", byte_q, hold);
    cmd(2'b10);
    chk(!halt, "R8", halt, 0);
    while (cmd_q[1] && cyc - c0 < W + 20) @(negedge clk);
    chk(cyc - c0 == W, "R8", cyc - c0, W);
    model[12] = 8'h90;
    known[12] = 1'b1;
    do_read(6'd12, "R2");

    // R9: both strobes at once
    set_loc(6'd20);
    set_byte(8'he1);
    cmd(2'b11);
    c0 = cyc;
    chk(cmd_q == exp_cmd_after(2'b11), "R9", cmd_q, 2);
    while (halt && cyc - c0 < 20) @(negedge clk);
    chk(cyc - c0 == 2, "R9", cyc - c0, 2);
    while (cmd_q[1] && cyc - c0 < W + 20) @(negedge clk);
    model[20] = 8'he1;
    known[20] = 1'b1;
    do_read(6'd20, "R9");

    // R10: reset in the middle of a program operation
    set_loc(6'd20);
    set_byte(8'h0f);
    cmd(2'b10);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(cmd_q == 2'b00 && !halt, "R10", {halt, cmd_q}, 0);
    chk(loc_q == 6'd0 && byte_q == 8'd0, "R10", {loc_q, byte_q}, 0);
    repeat (W + 5) @(negedge clk);
    do_read(6'd20, "R10");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule